// File: doc/BRIEF.md
# Fault Log Transfer Controller

This controller moves error-log bits between a local staging buffer and one of two error logging arrays, each owned by its own memory controller. The host issues a command strobe with a start address, an inclusive end address and a controller select. A read command copies the array bits from the start address through the end address into the staging buffer. The host then reads the buffer directly. For a write command, the host first fills the buffer. The command then copies the buffer into the array, usually as zeros to clear logged entries.

The logging arrays may only be touched during refresh slots. Each controller raises a refresh strobe for one cycle to open a slot. In the cycle after the strobe, the block moves exactly one entry and then steps its address counter. A comparator matches the counter against the end address. When they match, the transfer ends and a done flag is raised. The staging buffer holds `BUF_DEPTH` one-bit entries. Each entry is indexed by the low bits of the array address, so a transfer may span at most `BUF_DEPTH` entries.

Top module: `fault_log_xfer`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `arr_en` and `arr_we` are 0.
- R2: A command strobe is accepted only when the block is neither busy nor rejecting. While `busy` is 1, any command strobe is ignored: the running transfer keeps its controller, direction and end address.
- R3: A command is rejected in two cases: the end address is below the start address, or the command spans more than `BUF_DEPTH` entries (end minus start at least `BUF_DEPTH`). A rejected command sets `err` to 1, clears `done`, starts no transfer and touches no array. The next accepted command clears `err`.
- R4: `arr_en[k]` is 1 only in the cycle right after a cycle in which `refresh[k]` was 1. Each refresh strobe of the selected controller moves exactly one entry. A refresh strobe of the other controller has no effect.
- R5: A read command (`cmd_rd`) copies the array bit at each address a from start through end into buffer entry a mod `BUF_DEPTH`. The array is never written during a read.
- R6: A write command (`cmd_wr`) writes buffer entry a mod `BUF_DEPTH` into the array at each address a from start through end. Array addresses outside that range are left unchanged.
- R7: The transfer finishes after the entry at the end address is moved. In the next cycle `done` is 1 and `busy` is 0, and no further refresh strobe causes an access.
- R8: `host_buf_rdata` shows buffer entry `host_buf_idx` combinationally. `host_buf_we` writes the buffer only while `busy` is 0; a host write during a transfer is ignored.
- R9: When `cmd_rd` and `cmd_wr` are strobed together, the command is treated as a read.
- R10: `arr_en` bit 0 selects controller 0 and bit 1 selects controller 1. Only the controller named by `cmd_sel` at acceptance is ever enabled for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd | input | 1 | Read-command strobe (array to buffer) |
| cmd_wr | input | 1 | Write-command strobe (buffer to array) |
| cmd_sel | input | 1 | Controller select: 0 or 1 |
| cmd_lo | input | ADDR_W | Start array address |
| cmd_hi | input | ADDR_W | End array address, inclusive |
| host_buf_we | input | 1 | Host write strobe for the staging buffer |
| host_buf_idx | input | IDX_W | Staging-buffer entry index |
| host_buf_wdata | input | 1 | Host data written to the buffer |
| host_buf_rdata | output | 1 | Buffer entry at `host_buf_idx` |
| refresh | input | 2 | Refresh-slot strobe, one bit per controller |
| arr_en | output | 2 | Array access enable, one bit per controller |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 1 | Data written to the array |
| arr_rdata | input | 2 | Array read data, one bit per controller |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| err | output | 1 | Last command rejected |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 10 and `BUF_DEPTH` = 16. These values put the top array address 1023 within reach. They also allow a full 16-entry transfer whose start is not aligned, so buffer indices wrap from 15 to 0. A 17-entry request lands just past the rejection threshold. A monitor in the bench tracks every array access against the refresh strobe of the previous cycle. Separate arrays for the two controllers expose any access to the wrong controller, any write during a read, and any write outside the requested range.

// File: rtl/fault_log_xfer.sv
module fault_log_xfer #(
  parameter int ADDR_W    = 10,
  parameter int BUF_DEPTH = 16,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_sel,
  input  logic [ADDR_W-1:0] cmd_lo,
  input  logic [ADDR_W-1:0] cmd_hi,
  input  logic              host_buf_we,
  input  logic [IDX_W-1:0]  host_buf_idx,
  input  logic              host_buf_wdata,
  output logic              host_buf_rdata,
  input  logic [1:0]        refresh,
  output logic [1:0]        arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wdata,
  input  logic [1:0]        arr_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [ADDR_W:0] SPAN_LIM = (ADDR_W+1)'(BUF_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_DONE} st_t;

  st_t                  st_q;
  logic                 sel_q, wr_q, err_q;
  logic [ADDR_W-1:0]    cnt_q, end_q;
  logic [BUF_DEPTH-1:0] stage_q;

  wire              go     = cmd_rd | cmd_wr;
  wire              ready  = (st_q == S_IDLE) || (st_q == S_DONE);
  wire [ADDR_W:0]   span   = {1'b0, cmd_hi} - {1'b0, cmd_lo};
  wire              bad    = span[ADDR_W] || (span >= SPAN_LIM);
  wire              at_end = (cnt_q == end_q);
  wire              xfer   = (st_q == S_XFER);
  wire [IDX_W-1:0]  idx    = cnt_q[IDX_W-1:0];

  assign busy           = (st_q == S_WAIT) || xfer;
  assign done           = (st_q == S_DONE);
  assign err            = err_q;
  assign arr_en         = xfer ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
  assign arr_we         = xfer & wr_q;
  assign arr_addr       = cnt_q;
  assign arr_wdata      = stage_q[idx];
  assign host_buf_rdata = stage_q[host_buf_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
      cnt_q <= '0;
      end_q <= '0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE:
          if (go) begin
            if (bad) begin
              err_q <= 1'b1;
              st_q  <= S_IDLE;
            end else begin
              err_q <= 1'b0;
              sel_q <= cmd_sel;
              wr_q  <= ~cmd_rd;
              cnt_q <= cmd_lo;
              end_q <= cmd_hi;
              st_q  <= S_WAIT;
            end
          end
        S_WAIT:
          if (refresh[sel_q]) st_q <= S_XFER;
        S_XFER:
          if (at_end) st_q <= S_DONE;
          else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= S_WAIT;
          end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else if (xfer && !wr_q) stage_q[idx] <= arr_rdata[sel_q];
    else if (host_buf_we && !busy) stage_q[host_buf_idx] <= host_buf_wdata;
  end

  p_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|arr_en) |-> $past(refresh[sel_q]));

  p_hold_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> ($stable(sel_q) && $stable(wr_q) && $stable(end_q)));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer && at_end));

  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done && arr_en == 2'b00));

  p_no_write_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q) |-> !arr_we);
endmodule

// File: tb/tb_fault_log_xfer.sv
module tb_fault_log_xfer;
  localparam int AW = 10;
  localparam int BD = 16;
  localparam int IW = $clog2(BD);

  logic clk = 0, rst_n = 0;
  logic cmd_rd = 0, cmd_wr = 0, cmd_sel = 0;
  logic [AW-1:0] cmd_lo = '0, cmd_hi = '0;
  logic host_buf_we = 0, host_buf_wdata = 0;
  logic [IW-1:0] host_buf_idx = '0;
  logic host_buf_rdata;
  logic [1:0] refresh = 0, arr_en, arr_rdata;
  logic arr_we, arr_wdata, busy, done, err;
  logic [AW-1:0] arr_addr;

  logic mem0 [0:(1<<AW)-1];
  logic mem1 [0:(1<<AW)-1];
  logic [1:0] ref_d = 0;
  int n_acc = 0, n_viol = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  fault_log_xfer #(.ADDR_W(AW), .BUF_DEPTH(BD)) dut (.*);

  assign arr_rdata = {mem1[arr_addr], mem0[arr_addr]};

  always @(posedge clk) begin
    if (arr_en[0] && arr_we) mem0[arr_addr] <= arr_wdata;
    if (arr_en[1] && arr_we) mem1[arr_addr] <= arr_wdata;
    if (|arr_en) begin
      n_acc++;
      if ((arr_en & ~ref_d) != 0) n_viol++;
    end
    ref_d <= refresh;
  end

  function automatic logic pat(input int a);
    return a[0] ^ a[3] ^ a[5];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic command(input logic rd, input logic wr, input logic sel, input int lo, input int hi);
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_sel = sel;
    cmd_lo = AW'(lo); cmd_hi = AW'(hi);
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0;
  endtask

  task automatic pulse_refresh(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      refresh[k] = 1'b1;
      @(negedge clk);
      refresh[k] = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic buf_get(input int i, output logic v);
    host_buf_idx = IW'(i);
    #0.5 v = host_buf_rdata;
  endtask

  task automatic host_fill(input logic v);
    for (int i = 0; i < BD; i++) begin
      host_buf_we = 1; host_buf_idx = IW'(i); host_buf_wdata = v;
      @(negedge clk);
    end
    host_buf_we = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 arr_en", arr_en, 0);
    check("R1 arr_we", arr_we, 0);
  endtask

  task automatic t_read_basic();
    int acc0, bad;
    logic v;
    command(1, 0, 0, 100, 109);
    check("R2 busy after accept", busy, 1);
    acc0 = n_acc;
    repeat (4) @(negedge clk);
    check("R4 no access without refresh", n_acc - acc0, 0);
    pulse_refresh(1, 3);
    check("R4 other refresh ignored", n_acc - acc0, 0);
    command(0, 1, 1, 0, 3);
    pulse_refresh(0, 9);
    check("R4 one entry per strobe", n_acc - acc0, 9);
    check("R7 still busy before last", busy, 1);
    pulse_refresh(0, 1);
    check("R7 done", done, 1);
    check("R7 busy low", busy, 0);
    pulse_refresh(0, 2);
    check("R7 no access after done", n_acc - acc0, 10);
    bad = 0;
    for (int a = 100; a <= 109; a++) begin
      buf_get(a % BD, v);
      if (v !== pat(a)) bad++;
    end
    check("R5 buffer contents", bad, 0);
    bad = 0;
    for (int a = 0; a < 4; a++) if (mem1[a] !== pat(a)) bad++;
    check("R2 ignored write left ctl1 array intact", bad, 0);
  endtask

  task automatic t_read_ctl1_wrap();
    int acc0, bad;
    logic v;
    acc0 = n_acc;
    command(1, 0, 1, 250, 265);
    check("R3 16-entry span accepted", busy, 1);
    pulse_refresh(1, 16);
    check("R10 done on ctl1", done, 1);
    check("R4 sixteen accesses", n_acc - acc0, 16);
    bad = 0;
    for (int a = 250; a <= 265; a++) begin
      buf_get(a % BD, v);
      if (v !== pat(a)) bad++;
    end
    check("R5 wrapped buffer", bad, 0);
    command(1, 0, 1, 1020, 1023);
    pulse_refresh(1, 4);
    bad = 0;
    for (int a = 1020; a <= 1023; a++) begin
      buf_get(a % BD, v);
      if (v !== pat(a)) bad++;
    end
    check("R5 top addresses", done + 2 * bad, 1);
  endtask

  task automatic t_reject();
    int acc0;
    acc0 = n_acc;
    command(1, 0, 0, 10, 26);
    check("R3 17 entries rejected err", err, 1);
    check("R3 rejected not busy", busy, 0);
    check("R3 done cleared", done, 0);
    command(0, 1, 0, 30, 20);
    check("R3 reversed range err", err, 1);
    pulse_refresh(0, 2);
    check("R3 no access", n_acc - acc0, 0);
    command(1, 0, 0, 5, 5);
    check("R3 err cleared on accept", err, 0);
    pulse_refresh(0, 1);
    check("R3 single entry done", done, 1);
  endtask

  task automatic t_write_clear();
    int bad;
    for (int a = 98; a <= 111; a++) mem0[a] = 1'b1;
    host_fill(1'b0);
    command(0, 1, 0, 100, 109);
    host_buf_we = 1; host_buf_idx = IW'(100 % BD); host_buf_wdata = 1;
    @(negedge clk);
    host_buf_we = 0;
    pulse_refresh(0, 10);
    check("R6 write done", done, 1);
    bad = 0;
    for (int a = 100; a <= 109; a++) if (mem0[a] !== 1'b0) bad++;
    check("R8 host write ignored while busy / R6 cleared", bad, 0);
    check("R6 below range untouched", mem0[99], 1);
    check("R6 above range untouched", mem0[110], 1);
    check("R10 ctl1 untouched", mem1[100], pat(100));
  endtask

  task automatic t_host_buf();
    logic v;
    host_buf_we = 1; host_buf_idx = 3; host_buf_wdata = 1;
    @(negedge clk);
    host_buf_we = 0;
    buf_get(3, v);
    check("R8 host write idle", v, 1);
  endtask

  task automatic t_both_strobes();
    int bad;
    logic v;
    host_fill(1'b0);
    for (int a = 40; a <= 43; a++) mem0[a] = 1'b1;
    command(1, 1, 0, 40, 43);
    pulse_refresh(0, 4);
    bad = 0;
    for (int a = 40; a <= 43; a++) begin
      buf_get(a % BD, v);
      if (v !== 1'b1 || mem0[a] !== 1'b1) bad++;
    end
    check("R9 both strobes read", bad, 0);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin
      mem0[a] = pat(a);
      mem1[a] = pat(a);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_read_ctl1_wrap();
    t_reject();
    t_write_clear();
    t_host_buf();
    t_both_strobes();
    check("R4 accesses only after refresh", n_viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule